// File: doc/BRIEF.md
# Multi-Queue Spooling DMA Engine

This engine moves data between a set of per-gate word queues and a local memory that is 64 bits wide. Each spooling gate is set up at run time by a single configuration write that gives its direction (queue to memory, or memory to queue), a start address, an inclusive address limit and a count of 32-bit words. After that write the gate runs on its own. An inbound gate packs two queue words into one memory double word. An outbound gate fetches one double word and hands its two halves to its queue, low half first.

All gates share one memory request port. In every cycle a round-robin arbiter picks one gate that has a transfer ready, and that gate moves one double word and steps its address. Memory is addressed in double-word units. An inbound message may end early on an end-marker that travels with the data. An inbound gate whose address has run past its limit stops without writing and raises an overflow flag. A gate that completes normally raises a done flag.

Because memory is just consecutive addresses, an outbound gate pointed at the region an inbound gate fills lets memory act as a long extension of a queue.

Top module: `spool_dma`

## Requirements
- R1: After reset, every done and overflow flag is 0, mem_req is 0, every in_ready is 0 and every out_valid is 0.
- R2: A pulse on cfg_wr with cfg_gate = g loads gate g's direction (cfg_out: 1 = memory to queue, 0 = queue to memory), start address, limit and word count, and clears its done and overflow flags. A count of 0 sets done at once and starts no transfer.
- R3: At most one gate moves data per cycle. After gate g has won the bus, the next grant goes to the first requesting gate above g in index order, wrapping from the highest index to 0. Out of reset the search starts at gate 0.
- R4: Each gate uses consecutive memory addresses. It starts at its configured address and steps by one for every double word it moves.
- R5: An inbound gate stores the first queue word of a pair in mem_wdata bits 31:0 and the second in bits 63:32, with mem_be = 8'hFF.
- R6: Writes are allowed only while the gate's address is at or below its limit. An inbound gate holding data at an address beyond its limit writes nothing, sets its overflow flag and stops.
- R7: A gate sets done once it has moved its configured number of words. Done and overflow are never both set for the same gate.
- R8: An inbound word that carries in_last = 1 ends the message and sets done. If it is the first word of a pair, only the low half is written, with mem_be = 8'h0F.
- R9: An outbound gate presents the low half of each fetched double word before the high half. If its count is odd, only the low half of the last double word is presented. A presented word stays stable until out_ready takes it.
- R10: mem_req is high in every cycle in which any gate has a transfer ready, whether or not mem_gnt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_gate | input | GW | Gate index for the configuration write |
| cfg_out | input | 1 | 1 = memory to queue, 0 = queue to memory |
| cfg_base | input | AW | Start double-word address |
| cfg_limit | input | AW | Last double-word address allowed for writes |
| cfg_count | input | CW | Number of 32-bit words to move |
| in_valid | input | NG | Inbound queue word valid, one bit per gate |
| in_data | input | NG*32 | Inbound queue words, gate g in bits 32g+31:32g |
| in_last | input | NG | End-marker flag with the inbound word |
| in_ready | output | NG | Inbound word accepted |
| out_valid | output | NG | Outbound queue word valid |
| out_data | output | NG*32 | Outbound queue words, gate g in bits 32g+31:32g |
| out_ready | input | NG | Outbound word taken |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Double-word address |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Byte enables for writes |
| mem_gnt | input | 1 | Memory accepts the request this cycle; read data is valid alongside |
| mem_rdata | input | 64 | Read data |
| done | output | NG | Per-gate completion flag |
| ovf | output | NG | Per-gate limit-overflow flag |

## Verification
A wrong arbiter pointer shows on the first contested cycle as an address from the wrong gate's region on mem_addr. A wrong address or count register shows on the very next transfer of that gate, as a misplaced memory word or a done flag that comes too early or too late. A bad pairing of the pack buffer shows at once as swapped halves or wrong byte enables in the written double word. On the outbound side the same fault shows as words leaving the queue in the wrong order.

// File: rtl/spool_pkg.sv
package spool_pkg;
    localparam int QW = 32;
    localparam int DW = 64;
    localparam int BW = DW / 8;
    localparam logic [BW-1:0] BE_FULL = '1;
    localparam logic [BW-1:0] BE_LOW  = {{(BW/2){1'b0}}, {(BW/2){1'b1}}};
endpackage

// File: rtl/spool_rr_arb.sv
module spool_rr_arb #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr_d, ptr_q;
    logic          found;
    int            idx;

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        ptr_d = ptr_q;
        idx   = 0;
        for (int i = 1; i <= N; i++) begin
            idx = (int'(ptr_q) + i) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
                if (adv) ptr_d = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= IW'(N - 1);
        else        ptr_q <= ptr_d;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R3
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R3
endmodule

// File: rtl/spool_gate.sv
module spool_gate
    import spool_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_out,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_limit,
    input  logic [CW-1:0] cfg_count,
    input  logic          in_valid,
    input  logic [QW-1:0] in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          out_valid,
    output logic [QW-1:0] out_data,
    input  logic          out_ready,
    output logic          req,
    output logic          is_out,
    input  logic          win,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic [BW-1:0] be,
    input  logic [DW-1:0] rdata,
    output logic          done,
    output logic          ovf
);
    typedef struct packed {
        logic          active;
        logic          out;
        logic [AW-1:0] addr;
        logic [AW-1:0] limit;
        logic [CW-1:0] cnt;
        logic [QW-1:0] lo;
        logic [QW-1:0] hi;
        logic [1:0]    fill;
        logic          lo_end;
        logic          done;
        logic          ovf;
    } gate_st_t;

    gate_st_t s_d, s_q;
    logic in_mode, in_ok, hi_end;
    logic [1:0] take;

    always_comb begin
        s_d      = s_q;
        in_mode  = s_q.active && !s_q.out;
        in_ok    = s_q.addr <= s_q.limit;
        hi_end   = in_last || (s_q.cnt == CW'(2));
        take     = (s_q.cnt >= CW'(2)) ? 2'd2 : 2'd1;
        in_ready = 1'b0;
        req      = 1'b0;
        out_valid = s_q.active && s_q.out && (s_q.fill != 2'd0);
        if (in_mode) begin
            if (s_q.fill == 2'd0) begin
                in_ready = 1'b1;
            end else if (in_ok) begin
                req      = s_q.lo_end || in_valid;
                in_ready = !s_q.lo_end && win;
            end
        end else if (s_q.active && s_q.out) begin
            req = (s_q.fill == 2'd0) && (s_q.cnt != '0);
        end

        // inbound: first word of a pair
        if (in_mode && s_q.fill == 2'd0 && in_valid) begin
            s_d.lo     = in_data;
            s_d.fill   = 2'd1;
            s_d.lo_end = in_last || (s_q.cnt == CW'(1));
        end
        // inbound: beyond the limit
        if (in_mode && s_q.fill == 2'd1 && !in_ok) begin
            s_d.ovf    = 1'b1;
            s_d.active = 1'b0;
            s_d.fill   = 2'd0;
        end
        // inbound: double word written
        if (win && !s_q.out) begin
            s_d.addr = s_q.addr + AW'(1);
            s_d.fill = 2'd0;
            if (s_q.lo_end) begin
                s_d.cnt    = s_q.cnt - CW'(1);
                s_d.done   = 1'b1;
                s_d.active = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - CW'(2);
                if (hi_end) begin
                    s_d.done   = 1'b1;
                    s_d.active = 1'b0;
                end
            end
        end
        // outbound: double word fetched
        if (win && s_q.out) begin
            s_d.lo   = rdata[QW-1:0];
            s_d.hi   = rdata[DW-1:QW];
            s_d.fill = take;
            s_d.cnt  = s_q.cnt - CW'(take);
            s_d.addr = s_q.addr + AW'(1);
        end
        // outbound: word handed to the queue
        if (out_valid && out_ready) begin
            s_d.lo   = s_q.hi;
            s_d.fill = s_q.fill - 2'd1;
            if (s_q.fill == 2'd1 && s_q.cnt == '0) begin
                s_d.done   = 1'b1;
                s_d.active = 1'b0;
            end
        end
        if (cfg_wr) begin
            s_d        = '0;
            s_d.active = (cfg_count != '0);
            s_d.done   = (cfg_count == '0);
            s_d.out    = cfg_out;
            s_d.addr   = cfg_base;
            s_d.limit  = cfg_limit;
            s_d.cnt    = cfg_count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign is_out   = s_q.out;
    assign addr     = s_q.addr;
    assign out_data = s_q.lo;
    assign wdata    = {s_q.lo_end ? {QW{1'b0}} : in_data, s_q.lo};
    assign be       = s_q.lo_end ? BE_LOW : BE_FULL;
    assign done     = s_q.done;
    assign ovf      = s_q.ovf;

    AST_NO_WRITE_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (win && !s_q.out) |-> (s_q.addr <= s_q.limit)); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (win && !cfg_wr) |=> (s_q.addr == $past(s_q.addr) + AW'(1))); // R4
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.done && s_q.ovf)); // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !cfg_wr) |=> (out_valid && $stable(out_data))); // R9
endmodule

// File: rtl/spool_dma.sv
module spool_dma
    import spool_pkg::*;
#(
    parameter int NG = 8,
    parameter int AW = 16,
    parameter int CW = 16,
    localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [GW-1:0]    cfg_gate,
    input  logic             cfg_out,
    input  logic [AW-1:0]    cfg_base,
    input  logic [AW-1:0]    cfg_limit,
    input  logic [CW-1:0]    cfg_count,
    input  logic [NG-1:0]    in_valid,
    input  logic [NG*32-1:0] in_data,
    input  logic [NG-1:0]    in_last,
    output logic [NG-1:0]    in_ready,
    output logic [NG-1:0]    out_valid,
    output logic [NG*32-1:0] out_data,
    input  logic [NG-1:0]    out_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [63:0]      mem_wdata,
    output logic [7:0]       mem_be,
    input  logic             mem_gnt,
    input  logic [63:0]      mem_rdata,
    output logic [NG-1:0]    done,
    output logic [NG-1:0]    ovf
);
    logic [NG-1:0] req_v, gnt_v, dir_v;
    logic [AW-1:0] addr_v  [NG];
    logic [DW-1:0] wdata_v [NG];
    logic [BW-1:0] be_v    [NG];

    spool_rr_arb #(.N(NG)) arb_i (
        .clk(clk), .rst_n(rst_n), .req(req_v), .adv(mem_gnt), .gnt(gnt_v)
    );

    for (genvar g = 0; g < NG; g++) begin : g_gate
        spool_gate #(.AW(AW), .CW(CW)) gate_i (
            .clk(clk), .rst_n(rst_n),
            .cfg_wr(cfg_wr && (cfg_gate == GW'(g))),
            .cfg_out(cfg_out), .cfg_base(cfg_base),
            .cfg_limit(cfg_limit), .cfg_count(cfg_count),
            .in_valid(in_valid[g]), .in_data(in_data[g*QW +: QW]),
            .in_last(in_last[g]), .in_ready(in_ready[g]),
            .out_valid(out_valid[g]), .out_data(out_data[g*QW +: QW]),
            .out_ready(out_ready[g]),
            .req(req_v[g]), .is_out(dir_v[g]), .win(gnt_v[g] && mem_gnt),
            .addr(addr_v[g]), .wdata(wdata_v[g]), .be(be_v[g]),
            .rdata(mem_rdata), .done(done[g]), .ovf(ovf[g])
        );
    end

    always_comb begin
        mem_req   = |req_v;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        for (int g = 0; g < NG; g++) begin
            if (gnt_v[g]) begin
                mem_we    = !dir_v[g];
                mem_addr  = addr_v[g];
                mem_wdata = wdata_v[g];
                mem_be    = be_v[g];
            end
        end
    end

    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be == BE_FULL || mem_be == BE_LOW)); // R8
    AST_REQ_MEANS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $onehot(gnt_v)); // R10
endmodule

// File: tb/spool_dma_tb_top.sv
`timescale 1ns/1ps
module spool_dma_tb_top;
    localparam int NG = 8, AW = 16, CW = 16, GW = 3;

    logic clk = 0, rst_n = 0;
    logic cfg_wr = 0, cfg_out = 0;
    logic [GW-1:0] cfg_gate = 0;
    logic [AW-1:0] cfg_base = 0, cfg_limit = 0;
    logic [CW-1:0] cfg_count = 0;
    logic [NG-1:0] in_valid = 0, in_last = 0, out_ready = 0;
    logic [NG*32-1:0] in_data = 0;
    logic [NG-1:0] in_ready, out_valid, done, ovf;
    logic [NG*32-1:0] out_data;
    logic mem_req, mem_we, mem_gnt;
    logic [AW-1:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;
    logic [7:0] mem_be;
    logic gnt_en = 1;

    int total = 0, bad = 0;
    logic [63:0] mem [0:63];
    logic [AW-1:0] rlog [0:15];
    int nlog = 0;

    always #2.5 clk = ~clk;

    spool_dma #(.NG(NG), .AW(AW), .CW(CW)) dut_i (.*);

    assign mem_gnt   = gnt_en;
    assign mem_rdata = mem[mem_addr[5:0]];

    always @(posedge clk) begin
        if (mem_req && mem_gnt && mem_we)
            for (int b = 0; b < 8; b++)
                if (mem_be[b]) mem[mem_addr[5:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        if (mem_req && mem_gnt && !mem_we && nlog < 16) begin
            rlog[nlog] = mem_addr;
            nlog++;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic cfg(input int g, input bit o, input int base, input int lim, input int cnt);
        @(negedge clk);
        cfg_wr = 1; cfg_gate = GW'(g); cfg_out = o;
        cfg_base = AW'(base); cfg_limit = AW'(lim); cfg_count = CW'(cnt);
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic push(input int g, input logic [31:0] d, input bit last);
        int n = 0;
        in_valid[g] = 1; in_last[g] = last; in_data[g*32 +: 32] = d;
        #1;
        while (!in_ready[g] && n < 50) begin @(negedge clk); #1; n++; end
        @(negedge clk);
        in_valid[g] = 0; in_last[g] = 0;
    endtask

    task automatic pop(input int g, input logic [31:0] exp, input string what);
        int n = 0;
        while (!out_valid[g] && n < 50) begin @(negedge clk); n++; end
        chk(out_valid[g] && out_data[g*32 +: 32] == exp, what, out_data[g*32 +: 32], exp);
        out_ready[g] = 1;
        @(negedge clk);
        out_ready[g] = 0;
    endtask

    task automatic t_reset;
        chk(done == 0, "R1 done after reset", done, 0);
        chk(ovf == 0, "R1 ovf after reset", ovf, 0);
        chk(mem_req == 0, "R1 mem_req after reset", mem_req, 0);
        chk(in_ready == 0, "R1 in_ready after reset", in_ready, 0);
        chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    endtask

    task automatic t_inbound_pairs;
        cfg(2, 0, 8, 20, 4);
        push(2, 32'hA000_0000, 0);
        push(2, 32'hA000_0001, 0);
        push(2, 32'hA000_0002, 0);
        push(2, 32'hA000_0003, 0);
        @(negedge clk);
        chk(mem[8] == 64'hA000_0001_A000_0000, "R5 pair packing addr 8", mem[8], 64'hA000_0001_A000_0000);
        chk(mem[9] == 64'hA000_0003_A000_0002, "R4 next address 9", mem[9], 64'hA000_0003_A000_0002);
        chk(done[2] == 1, "R7 done after count", done[2], 1);
        chk(mem[10] == 64'hF000_000A_E000_000A, "R4 no write past count", mem[10], 64'hF000_000A_E000_000A);
    endtask

    task automatic t_marker_odd;
        cfg(3, 0, 16, 30, 10);
        push(3, 32'hB000_0000, 0);
        push(3, 32'hB000_0001, 0);
        chk(done[3] == 0, "R8 not done before marker", done[3], 0);
        push(3, 32'hB000_0002, 1);
        @(negedge clk);
        chk(mem[16] == 64'hB000_0001_B000_0000, "R8 first pair", mem[16], 64'hB000_0001_B000_0000);
        chk(mem[17] == 64'hF000_0011_B000_0002, "R8 odd end low half only", mem[17], 64'hF000_0011_B000_0002);
        chk(done[3] == 1, "R8 done on marker", done[3], 1);
    endtask

    task automatic t_limit;
        cfg(4, 0, 24, 24, 8);
        push(4, 32'hC000_0000, 0);
        push(4, 32'hC000_0001, 0);
        push(4, 32'hC000_0002, 0);
        @(negedge clk); @(negedge clk);
        chk(mem[24] == 64'hC000_0001_C000_0000, "R6 write at limit", mem[24], 64'hC000_0001_C000_0000);
        chk(mem[25] == 64'hF000_0019_E000_0019, "R6 no write beyond limit", mem[25], 64'hF000_0019_E000_0019);
        chk(ovf[4] == 1 && done[4] == 0, "R6 ovf set, done clear", {ovf[4], done[4]}, 2'b10);
        chk(in_ready[4] == 0, "R6 gate stopped", in_ready[4], 0);
        cfg(4, 0, 26, 30, 0);
        chk(ovf[4] == 0, "R2 config clears ovf", ovf[4], 0);
        chk(done[4] == 1 && mem_req == 0, "R2 count zero done at once", {done[4], mem_req}, 2'b10);
        cfg(2, 0, 40, 50, 2);
        chk(done[2] == 0, "R2 config clears done", done[2], 0);
        chk(in_ready[2] == 1, "R2 inbound direction loaded", in_ready[2], 1);
        cfg(2, 0, 40, 50, 0);
    endtask

    task automatic t_outbound;
        cfg(5, 1, 8, 0, 3);
        pop(5, 32'hA000_0000, "R9 low half first");
        pop(5, 32'hA000_0001, "R9 high half second");
        chk(done[5] == 0, "R7 outbound not yet done", done[5], 0);
        pop(5, 32'hA000_0002, "R9 odd count last low half");
        @(negedge clk);
        chk(done[5] == 1, "R7 outbound done after count", done[5], 1);
        chk(out_valid[5] == 0, "R9 no word after count", out_valid[5], 0);
    endtask

    task automatic t_round_robin;
        gnt_en = 0;
        cfg(0, 1, 32, 0, 4);
        cfg(1, 1, 40, 0, 4);
        cfg(6, 1, 48, 0, 4);
        chk(mem_req == 1, "R10 request while waiting for grant", mem_req, 1);
        nlog = 0;
        @(negedge clk); gnt_en = 1;
        repeat (4) @(negedge clk);
        chk(nlog == 3, "R3 three reads", nlog, 3);
        chk(rlog[0] == 48, "R3 first after gate 5 is gate 6", rlog[0], 48);
        chk(rlog[1] == 32, "R3 wrap to gate 0", rlog[1], 32);
        chk(rlog[2] == 40, "R3 then gate 1", rlog[2], 40);
        gnt_en = 0;
        pop(0, 32'hE000_0020, "R9 gate 0 low");
        pop(0, 32'hF000_0020, "R9 gate 0 high");
        pop(1, 32'hE000_0028, "R9 gate 1 low");
        pop(1, 32'hF000_0028, "R9 gate 1 high");
        nlog = 0;
        gnt_en = 1;
        repeat (4) @(negedge clk);
        chk(nlog == 2, "R3 two reads second round", nlog, 2);
        chk(rlog[0] == 33, "R4 gate 0 next address after gate 1 won", rlog[0], 33);
        chk(rlog[1] == 41, "R4 gate 1 next address", rlog[1], 41);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = {32'hF000_0000 | i, 32'hE000_0000 | i};
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_inbound_pairs();
        t_marker_odd();
        t_limit();
        t_outbound();
        t_round_robin();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule